// File: doc/BRIEF.md
# Multi-precision arithmetic unit

This block is the limb datapath for long-integer arithmetic. Each limb is `LIMB_W` bits wide (32 by default). Every operation yields a double-width value that is split over two destination words, low and high. Software loops over the limbs of a bignum and routes the high word back into the next step. That high word can be a carry, a borrow or the upper product half. Comparisons are chained through a one-bit flag.

A caller presents up to three limb sources, an opcode and an immediate shift amount, then raises `start_i` for one cycle. One clock edge later the results are registered, and `done_o` is high for that one cycle. The registered results stay unchanged until the next start. The result can be read in the cycle after issue.

Top module: `mpa_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dst_lo_o`, `dst_hi_o`, `flag_o` and `done_o` are cleared to zero.
- R2: `done_o` is high in exactly the cycle after a cycle with `start_i` high. The outputs are updated at that same edge. While `start_i` is low, all result outputs keep their values whatever the inputs do. A result value t is reported as `dst_lo_o` = t[W-1:0] and `dst_hi_o` = t[2W-1:W].
- R3: Opcode 0 gives t = src1 + src2. Opcode 1 gives t = src1 + src2 + src3[0]. Only bit 0 of src3 is used, so the carry ends up in bit 0 of the high word.
- R4: Opcode 2 gives t = src1 − src2. Opcode 3 gives t = (src1 − src2) − src3[0]. Both wrap modulo 2^(2W), so a borrow shows as an all-ones high word. Only bit 0 of src3 is used.
- R5: Opcode 4 gives t = src1 + src3. Opcode 5 gives t = src1 + src2 + src3, using the full width of every source.
- R6: Opcode 6 gives t = src1 × src2 + src3, unsigned. The product's upper half goes to the high destination.
- R7: Opcode 7 left-shifts the 2W-bit value {src2, src1} (src2 in the upper half) by src3. Opcode 8 does the same shift by `shamt_i`.
- R8: Opcode 9 logically right-shifts {src2, src1} by src3. Opcode 10 does the same shift by `shamt_i`.
- R9: A shift amount of 2W or more gives zero in both destinations, in both the register form and the immediate form.
- R10: Opcode 11 (equal step) sets the flag to (src1 == src2) AND src3[0].
- R11: Opcode 12 (less-than step) sets the flag to (src1 < src2) OR ((src1 == src2) AND src3[0]). Opcode 13 (greater-than step) is the same with >. The incoming flag src3[0] is the verdict already formed from the less significant limbs.
- R12: For opcodes 11 to 13, `flag_o` carries the outgoing flag, `dst_lo_o` equals the flag in bit 0 with zeros above, and `dst_hi_o` is zero. Every other opcode drives `flag_o` low.
- R13: Opcodes 14 and 15 are undefined. They give zero in both destinations and a low flag, and `done_o` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Issue strobe, one cycle per operation |
| op_i | input | 4 | Operation code |
| src1_i | input | LIMB_W | First source limb |
| src2_i | input | LIMB_W | Second source limb |
| src3_i | input | LIMB_W | Third source: addend, carry/borrow/flag in bit 0, or register shift amount |
| shamt_i | input | $clog2(2*LIMB_W)+1 | Immediate shift amount |
| dst_lo_o | output | LIMB_W | Low half of the result |
| dst_hi_o | output | LIMB_W | High half of the result |
| flag_o | output | 1 | Outgoing comparison flag |
| done_o | output | 1 | Result-valid pulse |

## Verification
The bench builds the unit with `LIMB_W` = 4, which makes the double-width value 8 bits and the immediate amount 4 bits. At that size every opcode can be swept against every pair of src1 and src2 values, with src3 covering both carry-bit values and high magnitudes. Shift amounts run across the full 0 to 15 range, so amounts of 8 and above exercise the out-of-range zeroing. After every issue the inputs are scrambled for one idle cycle to show that the held result does not move.

// File: rtl/mpa_pkg.sv
// Package mpa_pkg
// Shared opcode type for the multi-precision arithmetic unit.
// Assumes: a 4-bit operation code. Values 14 and 15 are undefined.
package mpa_pkg;

    typedef enum logic [3:0] {
        OP_ADD2  = 4'd0,
        OP_ADD3  = 4'd1,
        OP_SUB2  = 4'd2,
        OP_SUB3  = 4'd3,
        OP_ACC1  = 4'd4,
        OP_ACC2  = 4'd5,
        OP_MAC   = 4'd6,
        OP_SLL   = 4'd7,
        OP_SLLI  = 4'd8,
        OP_SRL   = 4'd9,
        OP_SRLI  = 4'd10,
        OP_EQU   = 4'd11,
        OP_LTU   = 4'd12,
        OP_GTU   = 4'd13,
        OP_RSV0  = 4'd14,
        OP_RSV1  = 4'd15
    } mpa_op_e;

    // Result routing classes chosen by the decoder
    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_SHIFT = 2'd1,
        CLS_CMP   = 2'd2,
        CLS_NONE  = 2'd3
    } mpa_cls_e;

endpackage

// File: rtl/mpa_arith.sv
// Module mpa_arith
// Combinational double-width add, subtract, accumulate and multiply-accumulate.
// It works on W-bit limbs and produces a 2W-bit result.
// Assumes: the caller only looks at the result for arithmetic opcodes.
// Subtraction wraps modulo 2^(2W).
module mpa_arith
    import mpa_pkg::*;
#(
    parameter int W = 32,
    localparam int DW = 2 * W
) (
    input  mpa_op_e         op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W-1:0]    c,
    output logic [DW-1:0]   t
);

    logic [DW-1:0] ea;
    logic [DW-1:0] eb;
    logic [DW-1:0] ec;
    logic [DW-1:0] ebit;
    logic [DW-1:0] prod;

    // Zero-extend the operands and isolate the carry/borrow bit
    always_comb begin
        ea   = DW'(a);
        eb   = DW'(b);
        ec   = DW'(c);
        ebit = DW'(c[0]);
        prod = ea * eb;
    end

    // Select the arithmetic form for the opcode
    always_comb begin
        unique case (op)
            OP_ADD2: t = ea + eb;
            OP_ADD3: t = ea + eb + ebit;
            OP_SUB2: t = ea - eb;
            OP_SUB3: t = (ea - eb) - ebit;
            OP_ACC1: t = ea + ec;
            OP_ACC2: t = ea + eb + ec;
            OP_MAC:  t = prod + ec;
            default: t = '0;
        endcase
    end

endmodule

// File: rtl/mpa_shift.sv
// Module mpa_shift
// Logarithmic barrel shifter on the 2W-bit value {hi, lo}.
// Each stage shifts by a power of two, left or right.
// An amount of 2W or more forces a zero result.
// Assumes: W is a power of two and at least 4, so the register-form amount
// has bits above the stage-select field.
module mpa_shift #(
    parameter int W = 32,
    localparam int DW = 2 * W,
    localparam int LG = $clog2(DW),
    localparam int SW = LG + 1
) (
    input  logic [W-1:0]    lo,
    input  logic [W-1:0]    hi,
    input  logic [W-1:0]    amt_reg,
    input  logic [SW-1:0]   amt_imm,
    input  logic            use_imm,
    input  logic            to_left,
    output logic [DW-1:0]   t
);

    logic [LG-1:0] amt;
    logic          too_far;
    logic [DW-1:0] stg [0:LG];

    // Pick the amount source and detect amounts beyond the value width
    always_comb begin
        if (use_imm) begin
            amt     = amt_imm[LG-1:0];
            too_far = amt_imm[SW-1];
        end else begin
            amt     = amt_reg[LG-1:0];
            too_far = |amt_reg[W-1:LG];
        end
    end

    assign stg[0] = {hi, lo};

    for (genvar k = 0; k < LG; k++) begin : g_stage
        // One stage: conditionally shift by 2**k in the chosen direction
        always_comb begin
            if (!amt[k])
                stg[k+1] = stg[k];
            else if (to_left)
                stg[k+1] = stg[k] << (2 ** k);
            else
                stg[k+1] = stg[k] >> (2 ** k);
        end
    end

    assign t = too_far ? '0 : stg[LG];

endmodule

// File: rtl/mpa_cmp.sv
// Module mpa_cmp
// One chained unsigned comparison step between two limbs.
// The incoming flag holds the verdict from the less significant limbs. It
// decides the outcome only when the current limbs are equal (it is required
// for the equality step).
// Assumes: limbs are processed from least to most significant.
module mpa_cmp
    import mpa_pkg::*;
#(
    parameter int W = 32
) (
    input  mpa_op_e         op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            fin,
    output logic            fout
);

    logic eq;
    logic lt;
    logic gt;

    // Raw limb relations
    always_comb begin
        eq = (a == b);
        lt = (a < b);
        gt = (a > b);
    end

    // Merge the raw relation with the incoming chain flag
    always_comb begin
        unique case (op)
            OP_EQU:  fout = eq & fin;
            OP_LTU:  fout = lt | (eq & fin);
            OP_GTU:  fout = gt | (eq & fin);
            default: fout = 1'b0;
        endcase
    end

endmodule

// File: rtl/mpa_unit.sv
// Module mpa_unit
// Top of the multi-precision arithmetic unit.
// It decodes the opcode, routes the sources to the arithmetic, shift or
// compare datapath, and registers the 2W-bit result as a low and a high
// limb one cycle after start.
// Assumes: one operation per start pulse. The outputs hold between starts.
module mpa_unit
    import mpa_pkg::*;
#(
    parameter int LIMB_W = 32,
    localparam int DW = 2 * LIMB_W,
    localparam int LG = $clog2(DW),
    localparam int SHAMT_W = LG + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [3:0]          op_i,
    input  logic [LIMB_W-1:0]   src1_i,
    input  logic [LIMB_W-1:0]   src2_i,
    input  logic [LIMB_W-1:0]   src3_i,
    input  logic [SHAMT_W-1:0]  shamt_i,
    output logic [LIMB_W-1:0]   dst_lo_o,
    output logic [LIMB_W-1:0]   dst_hi_o,
    output logic                flag_o,
    output logic                done_o
);

    mpa_op_e       op;
    mpa_cls_e      cls;
    logic          shf_imm;
    logic          shf_left;
    logic [DW-1:0] arith_t;
    logic [DW-1:0] shift_t;
    logic          cmp_f;
    logic [DW-1:0] next_t;
    logic          next_f;

    assign op = mpa_op_e'(op_i);

    // Decode the opcode into a result class and shifter controls
    always_comb begin
        shf_imm  = 1'b0;
        shf_left = 1'b0;
        unique case (op)
            OP_ADD2, OP_ADD3, OP_SUB2, OP_SUB3,
            OP_ACC1, OP_ACC2, OP_MAC:   cls = CLS_ARITH;
            OP_SLL:  begin cls = CLS_SHIFT; shf_left = 1'b1; end
            OP_SLLI: begin cls = CLS_SHIFT; shf_left = 1'b1; shf_imm = 1'b1; end
            OP_SRL:  cls = CLS_SHIFT;
            OP_SRLI: begin cls = CLS_SHIFT; shf_imm = 1'b1; end
            OP_EQU, OP_LTU, OP_GTU:     cls = CLS_CMP;
            default:                    cls = CLS_NONE;
        endcase
    end

    mpa_arith #(.W(LIMB_W)) i_arith (
        .op (op),
        .a  (src1_i),
        .b  (src2_i),
        .c  (src3_i),
        .t  (arith_t)
    );

    mpa_shift #(.W(LIMB_W)) i_shift (
        .lo      (src1_i),
        .hi      (src2_i),
        .amt_reg (src3_i),
        .amt_imm (shamt_i),
        .use_imm (shf_imm),
        .to_left (shf_left),
        .t       (shift_t)
    );

    mpa_cmp #(.W(LIMB_W)) i_cmp (
        .op   (op),
        .a    (src1_i),
        .b    (src2_i),
        .fin  (src3_i[0]),
        .fout (cmp_f)
    );

    // Select the result of the active datapath
    always_comb begin
        unique case (cls)
            CLS_ARITH: begin next_t = arith_t;   next_f = 1'b0;  end
            CLS_SHIFT: begin next_t = shift_t;   next_f = 1'b0;  end
            CLS_CMP:   begin next_t = DW'(cmp_f); next_f = cmp_f; end
            default:   begin next_t = '0;        next_f = 1'b0;  end
        endcase
    end

    // Register the split result on start and pulse done for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_lo_o <= '0;
            dst_hi_o <= '0;
            flag_o   <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                dst_lo_o <= next_t[LIMB_W-1:0];
                dst_hi_o <= next_t[DW-1:LIMB_W];
                flag_o   <= next_f;
            end
        end
    end

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);    // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);  // R2
    AST_HOLD_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(dst_lo_o) && $stable(dst_hi_o) && $stable(flag_o)));  // R2
    AST_ADD2_CARRY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == 4'd0) |=> (dst_hi_o[LIMB_W-1:1] == '0));  // R3
    AST_IMM_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (op_i == 4'd8 || op_i == 4'd10) && shamt_i[SHAMT_W-1])
        |=> (dst_lo_o == '0 && dst_hi_o == '0));  // R9
    AST_CMP_RESULT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i >= 4'd11 && op_i <= 4'd13)
        |=> (dst_hi_o == '0 && dst_lo_o == LIMB_W'(flag_o)));  // R12
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i >= 4'd14)
        |=> (dst_lo_o == '0 && dst_hi_o == '0 && !flag_o));  // R13

endmodule

// File: tb/test_mpa_unit.sv
// Bench for mpa_unit built with 4-bit limbs. It sweeps every opcode against
// every src1/src2 pair and a spread of src3 and shift amounts, and computes
// the expected values arithmetically.
module test_mpa_unit;

    localparam int W  = 4;
    localparam int DW = 2 * W;
    localparam int SW = $clog2(DW) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    op = '0;
    logic [W-1:0]  s1 = '0;
    logic [W-1:0]  s2 = '0;
    logic [W-1:0]  s3 = '0;
    logic [SW-1:0] sh = '0;
    logic [W-1:0]  lo;
    logic [W-1:0]  hi;
    logic          fl;
    logic          dn;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;  // 50 MHz

    mpa_unit #(.LIMB_W(W)) i_mpa_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .op_i     (op),
        .src1_i   (s1),
        .src2_i   (s2),
        .src3_i   (s3),
        .shamt_i  (sh),
        .dst_lo_o (lo),
        .dst_hi_o (hi),
        .flag_o   (fl),
        .done_o   (dn)
    );

    // Compare all outputs against the expected values and log a miscompare
    task automatic chk(input string req, input logic [DW-1:0] et,
                       input logic ef, input logic ed);
        vectors++;
        if ({hi, lo} !== et || fl !== ef || dn !== ed) begin
            errors++;
            $display("FAIL %s op=%0d s1=%0d s2=%0d s3=%0d sh=%0d: got hi/lo=%h flag=%b done=%b, expected %h flag=%b done=%b",
                     req, op, s1, s2, s3, sh, {hi, lo}, fl, dn, et, ef, ed);
        end
    endtask

    // Requirement tag for a given opcode and amount
    function automatic string tag(input int o, input int amt);
        case (o)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4, 5:    return "R5";
            6:       return "R6";
            7, 8:    return (amt >= DW) ? "R9" : "R7";
            9, 10:   return (amt >= DW) ? "R9" : "R8";
            11:      return "R10";
            12, 13:  return "R11";
            default: return "R13";
        endcase
    endfunction

    // Expected double-width result from the requirement formulas
    function automatic logic [DW-1:0] model(input int o, input int a, input int b,
                                            input int c, input int s);
        int cat;
        cat = (b << W) | a;
        case (o)
            0:  return DW'(a + b);
            1:  return DW'(a + b + (c & 1));
            2:  return DW'(a - b);
            3:  return DW'(a - b - (c & 1));
            4:  return DW'(a + c);
            5:  return DW'(a + b + c);
            6:  return DW'(a * b + c);
            7:  return (c >= DW) ? '0 : DW'(cat << c);
            8:  return (s >= DW) ? '0 : DW'(cat << s);
            9:  return (c >= DW) ? '0 : DW'(cat >> c);
            10: return (s >= DW) ? '0 : DW'(cat >> s);
            11: return DW'((a == b) && (c & 1));
            12: return DW'((a < b) || ((a == b) && (c & 1)));
            13: return DW'((a > b) || ((a == b) && (c & 1)));
            default: return '0;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Stimulus and checking
    initial begin
        logic [DW-1:0] exp_t;
        logic          exp_f;
        int            amt;
        repeat (3) @(negedge clk);
        chk("R1", '0, 1'b0, 1'b0);          // reset state
        s1 = 4'hF; s2 = 4'hF; op = 4'd6; start = 1'b1;
        @(negedge clk);
        chk("R1", '0, 1'b0, 1'b0);          // start ignored in reset
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", '0, 1'b0, 1'b0);
        for (int o = 0; o < 16; o++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int c = 0; c < 16; c += 3) begin
                        op = 4'(o); s1 = W'(a); s2 = W'(b); s3 = W'(c);
                        sh = SW'(c ^ a);
                        amt = (o == 8 || o == 10) ? (c ^ a) : c;
                        exp_t = model(o, a, b, c, c ^ a);
                        exp_f = (o >= 11 && o <= 13) ? exp_t[0] : 1'b0;
                        start = 1'b1;
                        @(negedge clk);
                        chk(tag(o, amt), exp_t, exp_f, 1'b1);
                        start = 1'b0;
                        s1 = ~s1; s2 = s2 + 4'd5; s3 = ~s3; sh = ~sh; op = ~op;
                        @(negedge clk);
                        chk("R2", exp_t, exp_f, 1'b0);  // held while idle
                    end
                end
            end
        end
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", '0, 1'b0, 1'b0);          // reset clears a held result
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule